// File: doc/BRIEF.md
# Fixed-Priority Hold-Until-Release Arbiter

This block is a Moore-style control unit that hands one shared resource to one of a small set of requesters (three by default). Each requester raises its own request bit and the block answers with a one-hot grant vector. Arbitration takes place only while the block is idle. When several requests are pending at that moment, the lowest-numbered requester wins.

Once a requester has been granted, it keeps the grant for as long as its request stays high. No other request can take the grant away, including one with higher priority. When the owning request drops, the block returns to idle for one cycle. It arbitrates again from there.

The grants are decoded purely from the state register. The state encoding is chosen by a parameter, either one-hot or binary, and both encodings give identical port behaviour.

Top module: `prio_hold_arbiter`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after a clock edge that samples `rst` high, `grant` is all zeros, whatever the state was before.
- R2: At most one bit of `grant` is set in any cycle.
- R3: When `grant` is all zeros and `req` is non-zero at a rising edge, `grant` in the next cycle has exactly one bit set: the lowest-index set bit of `req`. Bit 0 has the highest priority.
- R4: When `grant` is all zeros and `req` is all zeros at a rising edge, `grant` stays all zeros in the next cycle.
- R5: While `grant[i]` is set and `req[i]` is high at a rising edge, `grant` is unchanged in the next cycle, whatever the other request bits do.
- R6: While `grant[i]` is set and `req[i]` is low at a rising edge, `grant` is all zeros in the next cycle.
- R7: `grant` never moves directly from one requester to another. At least one all-zero cycle separates two different grants.
- R8: The one-hot encoding (`ENC = ENC_ONEHOT`) and the binary encoding (`ENC = ENC_BINARY`) produce identical `grant` sequences for the same `rst`/`req` stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_REQ | Request lines; bit 0 has the highest priority |
| grant | output | N_REQ | One-hot (or zero) grant lines, decoded from the state |

## Verification
The checker watches the per-cycle rules on every clock edge:
- grants stay one-hot or zero;
- the idle pick goes to the lowest request;
- the idle state holds when no request is present;
- a grant holds while its request stays high and clears when it drops;
- the grant never moves straight from one requester to another.

Whether the two state encodings are truly equivalent can only be shown by the bench. It drives the one-hot and binary builds side by side through the same scenarios: simultaneous requests, a higher-priority request arriving during a hold, back-to-back handoffs, and a reset in the middle of a grant.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic {
    ENC_BINARY = 1'b0,
    ENC_ONEHOT = 1'b1
  } enc_e;

  localparam int MAX_REQ = 32;

  // isolate the lowest set bit of a request vector
  function automatic logic [MAX_REQ-1:0] lowest_set(input logic [MAX_REQ-1:0] v);
    return v & (~v + 1'b1);
  endfunction

endpackage

// File: rtl/arb_next.sv
module arb_next #(
  parameter int N_REQ = 3
) (
  input  logic [N_REQ-1:0] req,
  input  logic [N_REQ-1:0] own,
  output logic [N_REQ-1:0] nxt_own,
  output logic             start_evt,
  output logic             rel_evt
);
  import arb_pkg::*;

  logic [MAX_REQ-1:0] wide_req;
  logic [MAX_REQ-1:0] wide_pick;
  logic [N_REQ-1:0]   pick;
  logic               idle;
  logic               keep;

  assign wide_req  = MAX_REQ'(req);
  assign wide_pick = lowest_set(wide_req);
  assign pick      = wide_pick[N_REQ-1:0];
  assign idle      = (own == '0);
  assign keep      = |(own & req);

  always_comb begin
    if (idle)      nxt_own = pick;
    else if (keep) nxt_own = own;
    else           nxt_own = '0;
  end

  assign start_evt = idle & (|req);
  assign rel_evt   = ~idle & ~keep;

endmodule

// File: rtl/arb_state.sv
module arb_state #(
  parameter int            N_REQ = 3,
  parameter arb_pkg::enc_e ENC   = arb_pkg::ENC_ONEHOT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] nxt_own,
  output logic [N_REQ-1:0] own
);
  localparam int BW = $clog2(N_REQ + 1);

  function automatic logic [BW-1:0] to_bin(input logic [N_REQ-1:0] oh);
    logic [BW-1:0] r;
    r = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (oh[i]) r = BW'(i + 1);
    end
    return r;
  endfunction

  function automatic logic [N_REQ-1:0] from_bin(input logic [BW-1:0] b);
    logic [N_REQ-1:0] r;
    r = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (b == BW'(i + 1)) r[i] = 1'b1;
    end
    return r;
  endfunction

  generate
    if (ENC == arb_pkg::ENC_ONEHOT) begin : g_onehot
      // bit 0 is the idle state, bit i+1 owns requester i
      logic [N_REQ:0] st;
      always_ff @(posedge clk) begin
        if (rst) st <= {{N_REQ{1'b0}}, 1'b1};
        else     st <= {nxt_own, ~(|nxt_own)};
      end
      assign own = st[N_REQ:1];
    end else begin : g_binary
      // code 0 is idle, code i+1 owns requester i
      logic [BW-1:0] st;
      always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= to_bin(nxt_own);
      end
      assign own = from_bin(st);
    end
  endgenerate

endmodule

// File: rtl/arb_decode.sv
module arb_decode #(
  parameter int N_REQ = 3
) (
  input  logic [N_REQ-1:0] own,
  output logic [N_REQ-1:0] grant
);
  generate
    for (genvar i = 0; i < N_REQ; i++) begin : g_lane
      assign grant[i] = own[i];
    end
  endgenerate
endmodule

// File: rtl/prio_hold_arbiter.sv
module prio_hold_arbiter #(
  parameter int            N_REQ = 3,
  parameter arb_pkg::enc_e ENC   = arb_pkg::ENC_ONEHOT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] grant
);
  logic [N_REQ-1:0] own;
  logic [N_REQ-1:0] nxt_own;
  logic             start_evt;
  logic             rel_evt;

  arb_next #(.N_REQ(N_REQ)) u_next (
    .req(req), .own(own), .nxt_own(nxt_own),
    .start_evt(start_evt), .rel_evt(rel_evt)
  );

  arb_state #(.N_REQ(N_REQ), .ENC(ENC)) u_state (
    .clk(clk), .rst(rst), .nxt_own(nxt_own), .own(own)
  );

  arb_decode #(.N_REQ(N_REQ)) u_dec (
    .own(own), .grant(grant)
  );

endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int N_REQ = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [N_REQ-1:0] req,
  input logic [N_REQ-1:0] grant,
  input logic             start_evt,
  input logic             rel_evt
);
  function automatic logic [N_REQ-1:0] low_bit(input logic [N_REQ-1:0] v);
    logic [N_REQ-1:0] r;
    r = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (v[i]) r = '0;
      if (v[i]) r[i] = 1'b1;
    end
    return r;
  endfunction

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (grant == '0));

  // R2
  onehot_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R3
  idle_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && req != '0) |=> (grant == low_bit($past(req))));

  // R3
  start_evt_chk: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (grant != '0));

  // R4
  idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && req == '0) |=> (grant == '0));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((grant & req) != '0) |=> $stable(grant));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    rel_evt |=> (grant == '0));

  // R7
  no_handoff_chk: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |=> (grant == $past(grant) || grant == '0));

endmodule

bind prio_hold_arbiter arb_chk #(.N_REQ(N_REQ)) u_arb_chk (
  .clk(clk), .rst(rst), .req(req), .grant(grant),
  .start_evt(start_evt), .rel_evt(rel_evt)
);

// File: tb/prio_hold_arbiter_tb.sv
module prio_hold_arbiter_tb;
  localparam int N = 3;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [N-1:0] grant_oh;
  logic [N-1:0] grant_bin;

  int    n_vec  = 0;
  int    n_bad  = 0;
  bit    done   = 1'b0;
  item_t sb[$];
  logic [N-1:0] mdl = '0;

  always #5 clk = ~clk;

  prio_hold_arbiter #(.N_REQ(N), .ENC(arb_pkg::ENC_ONEHOT)) u_dut (
    .clk(clk), .rst(rst), .req(req), .grant(grant_oh)
  );

  prio_hold_arbiter #(.N_REQ(N), .ENC(arb_pkg::ENC_BINARY)) u_dut_bin (
    .clk(clk), .rst(rst), .req(req), .grant(grant_bin)
  );

  // reference model written from the requirements
  task automatic step(input logic r, input logic [N-1:0] v, input string tag);
    item_t it;
    @(negedge clk);
    rst = r;
    req = v;
    if (r) mdl = '0;
    else if (mdl == '0) begin
      mdl = '0;
      for (int i = N - 1; i >= 0; i--) if (v[i]) begin mdl = '0; mdl[i] = 1'b1; end
    end else if ((mdl & v) == '0) mdl = '0;
    it.exp = mdl;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: 2 ns after each rising edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        n_vec++;
        if (grant_oh !== it.exp) begin
          n_bad++;
          $display("FAIL %s one-hot build: grant=%b expected=%b", it.tag, grant_oh, it.exp);
        end
        if (grant_bin !== it.exp) begin
          n_bad++;
          $display("FAIL R8 (%s) binary build: grant=%b expected=%b", it.tag, grant_bin, it.exp);
        end
        if ($countones(grant_oh) > 1) begin
          n_bad++;
          $display("FAIL R2 grant=%b expected at most one bit", grant_oh);
        end
      end
    end
  end

  initial begin
    step(1'b1, 3'b111, "R1");
    step(1'b1, 3'b000, "R1");
    step(1'b0, 3'b000, "R4");
    step(1'b0, 3'b000, "R4");
    step(1'b0, 3'b111, "R3");
    step(1'b0, 3'b001, "R5");
    step(1'b0, 3'b000, "R6");
    step(1'b0, 3'b110, "R3");
    step(1'b0, 3'b011, "R5");
    step(1'b0, 3'b111, "R5");
    step(1'b0, 3'b101, "R6");
    step(1'b0, 3'b101, "R7");
    step(1'b0, 3'b100, "R6");
    step(1'b0, 3'b100, "R3");
    step(1'b0, 3'b111, "R5");
    step(1'b0, 3'b110, "R5");
    step(1'b0, 3'b011, "R6");
    step(1'b0, 3'b011, "R7");
    step(1'b0, 3'b010, "R6");
    step(1'b0, 3'b010, "R3");
    step(1'b0, 3'b010, "R5");
    step(1'b1, 3'b010, "R1");
    step(1'b0, 3'b000, "R4");
    step(1'b0, 3'b100, "R3");
    step(1'b0, 3'b000, "R6");
    step(1'b0, 3'b001, "R3");
    step(1'b0, 3'b000, "R6");
    step(1'b0, 3'b000, "R4");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule